// File: doc/BRIEF.md
# Reset Source Controller and Vector Loader

This block merges every reset request of a small 8-bit controller into one system reset and then brings the CPU up by fetching its start-up vectors from program memory. Five requesters are handled: a power-on pulse, an active-low external reset pin, a low-speed oscillator stop detect, a two-stage watchdog overflow, and a software break request that carries the current two-bit interrupt level. Any request cancels whatever the block is doing, including a vector fetch already under way, and the fetch starts again once all requests are gone.

Hardware requests reset the CPU, the peripheral registers with defined initial values and the power circuit. A break request resets the CPU alone, and when its interrupt level is 1 or less the program counter is taken from an alternate vector pair. After the hold phase the block reads four bytes through a byte-wide read port with one cycle of latency. It loads a 16-bit stack pointer and program counter from them, and it releases the CPU reset only after both are complete. A sticky cause register records which requesters fired. Software clears its bits by writing ones.

Top module: `rst_hub_ctrl`

## Requirements
- R1: Each of the five requesters (power-on pulse, pin, oscillator stop, second watchdog overflow, break) asserts `cpu_rst` and leads to a complete vector fetch.
- R2: The pin passes through two synchronizer flops and counts as a request only when its synchronized value stays low for at least 2 consecutive cycles. A low pulse of one cycle never asserts `cpu_rst`.
- R3: The first watchdog overflow only sets `wdt_pending` and does not reset. A second overflow while `wdt_pending` is 1 raises a reset. Pulsing `wdt_pend_clr` between the two overflows prevents the reset. The reset also clears `wdt_pending`.
- R4: A break request that comes without any hardware request asserts `cpu_rst` but never `sfr_rst` or `pwr_rst`.
- R5: A hardware request asserts `cpu_rst`, `sfr_rst` and `pwr_rst` together on the clock edge after it is seen.
- R6: The stack pointer low byte comes from byte address 0 and the high byte from address 1.
- R7: After a hardware reset, the program counter low byte comes from address 2 and the high byte from address 3.
- R8: After a break reset with an interrupt level of 0 or 1, the program counter comes from addresses 4 (low) and 5 (high). With a level of 2 or 3 it comes from addresses 2 and 3.
- R9: When a break and a hardware request occur in the same cycle, the hardware reset wins: all three resets assert and the normal vector at addresses 2 and 3 is used.
- R10: A request that arrives during a vector fetch keeps `cpu_rst` asserted, discards the partial fetch and starts the fetch again from address 0.
- R11: The reads go out in the order SP low, SP high, PC low, PC high. After a one-cycle break pulse, `cpu_rst` first reads low 7 cycles after the cycle of the pulse, once both registers are loaded.
- R12: The cause register uses bit 0 for the pin, bit 1 for power-on, bit 2 for oscillator stop, bit 3 for the watchdog and bit 4 for break. Its bits are sticky. Writing 1 in `cause_clr` clears a bit, but a new event in the same cycle keeps the bit set.
- R13: A power-on pulse leaves the cause register at 5'b00010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_pulse | input | 1 | Power-on detect; synchronous active-high reset of the whole block |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| osc_stop | input | 1 | Low-speed oscillator stop detected |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_pend_clr | input | 1 | Software clear of the watchdog pending flag |
| brk_req | input | 1 | Software break reset request |
| brk_ilvl | input | 2 | Interrupt level at the time of the break |
| cause_clr | input | 5 | Write-one-to-clear mask for the cause register |
| mem_rdata | input | 8 | Program memory read data, one cycle after the address |
| cpu_rst | output | 1 | CPU reset, high until the vectors are loaded |
| sfr_rst | output | 1 | Peripheral register reset (hardware sources only) |
| pwr_rst | output | 1 | Power circuit reset (hardware sources only) |
| mem_re | output | 1 | Program memory read enable |
| mem_addr | output | 16 | Program memory byte address |
| sp_q | output | 16 | Loaded stack pointer |
| pc_q | output | 16 | Loaded program counter |
| cause_q | output | 5 | Sticky reset cause bits |
| wdt_pending | output | 1 | First watchdog overflow seen |

## Verification
The hardest state to reach is a reset that lands in the middle of a vector fetch, with the partial stack pointer already captured and the read pipeline still holding a byte in flight. The bench reaches it by issuing a break and then pulsing the oscillator stop input a fixed number of cycles later, so the second request lands while reads are outstanding. It then checks that the reset never drops and that the final values match a clean fetch. The same arithmetic byte pattern is used across a sweep of every requester against every interrupt level, so a wrong vector choice or a wrong byte order gives a wrong value.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_SP_LO,
    ST_SP_HI,
    ST_PC_LO,
    ST_PC_HI,
    ST_RUN
  } seq_st_t;

  localparam int SRC_N   = 5;
  localparam int SRC_PIN = 0;
  localparam int SRC_POR = 1;
  localparam int SRC_OSC = 2;
  localparam int SRC_WDT = 3;
  localparam int SRC_BRK = 4;
endpackage

// File: rtl/rst_pin_filt.sv
module rst_pin_filt #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic req
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);
  localparam logic [CW-1:0] CNT_THR = CW'(MIN_LOW - 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      cnt <= '0;
      req <= 1'b0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      if (s2) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      req <= !s2 && (cnt >= CNT_THR);
    end
  end

  generate
    if (MIN_LOW >= 2) begin : g_chk
      AST_PIN_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> (!$past(s2) && !$past(s2, 2))); // R2
    end
  endgenerate
endmodule

// File: rtl/rst_wdt_arm.sv
module rst_wdt_arm (
  input  logic clk,
  input  logic rst,
  input  logic clr_hw,
  input  logic ovf,
  input  logic sw_clr,
  output logic pend,
  output logic fire
);
  always_ff @(posedge clk) begin
    if (rst || clr_hw) begin
      pend <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= ovf && pend && !sw_clr;
      if (sw_clr) pend <= 1'b0;
      else if (ovf && pend) pend <= 1'b0;
      else if (ovf) pend <= 1'b1;
    end
  end

  AST_WDT_TWO_STEP: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(pend)); // R3
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] set,
  input  logic [SRC_N-1:0] clr,
  output logic [SRC_N-1:0] cause
);
  localparam logic [SRC_N-1:0] POR_ONLY = SRC_N'(1) << SRC_POR;

  always_ff @(posedge clk) begin
    if (rst) cause <= POR_ONLY;
    else     cause <= (cause & ~clr) | set;
  end

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((~cause & $past(cause)) != '0) |-> ((~cause & $past(cause) & ~$past(clr)) == '0)); // R12
endmodule

// File: rtl/rst_vec_seq.sv
module rst_vec_seq
  import rst_hub_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ILVL_W      = 2,
  parameter int BRK_ALT_MAX = 1,
  parameter int SP_VEC      = 0,
  parameter int PC_VEC      = 2,
  parameter int PC_BRK_VEC  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hw_req,
  input  logic                brk_req,
  input  logic [ILVL_W-1:0]   brk_ilvl,
  input  logic [DATA_W-1:0]   rdata,
  output logic                cpu_rst,
  output logic                sfr_rst,
  output logic                pwr_rst,
  output logic                mem_re,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] sp,
  output logic [2*DATA_W-1:0] pc
);
  localparam logic [ILVL_W-1:0] ALT_LVL = ILVL_W'(BRK_ALT_MAX);
  localparam logic [ADDR_W-1:0] A_SP  = ADDR_W'(SP_VEC);
  localparam logic [ADDR_W-1:0] A_PC  = ADDR_W'(PC_VEC);
  localparam logic [ADDR_W-1:0] A_BRK = ADDR_W'(PC_BRK_VEC);

  seq_st_t state, nxt, cap;
  logic    cap_v, alt, any_req;

  assign any_req = hw_req || brk_req;

  function automatic logic is_read(input seq_st_t s);
    return (s == ST_SP_LO) || (s == ST_SP_HI) || (s == ST_PC_LO) || (s == ST_PC_HI);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(input seq_st_t s, input logic a);
    logic [ADDR_W-1:0] pcb;
    pcb = a ? A_BRK : A_PC;
    case (s)
      ST_SP_LO: return A_SP;
      ST_SP_HI: return A_SP + 1'b1;
      ST_PC_LO: return pcb;
      ST_PC_HI: return pcb + 1'b1;
      default:  return A_SP;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    if (any_req) nxt = ST_HOLD;
    else begin
      case (state)
        ST_HOLD:  nxt = ST_SP_LO;
        ST_SP_LO: nxt = ST_SP_HI;
        ST_SP_HI: nxt = ST_PC_LO;
        ST_PC_LO: nxt = ST_PC_HI;
        ST_PC_HI: nxt = ST_RUN;
        default:  nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HOLD;
      cpu_rst  <= 1'b1;
      sfr_rst  <= 1'b1;
      pwr_rst  <= 1'b1;
      alt      <= 1'b0;
      cap      <= ST_HOLD;
      cap_v    <= 1'b0;
      sp       <= '0;
      pc       <= '0;
      mem_re   <= 1'b0;
      mem_addr <= '0;
    end else begin
      state    <= nxt;
      cpu_rst  <= (state != ST_RUN) || any_req;
      sfr_rst  <= hw_req;
      pwr_rst  <= hw_req;
      mem_re   <= is_read(nxt);
      mem_addr <= addr_of(nxt, alt);
      if (any_req) begin
        alt   <= !hw_req && (brk_ilvl <= ALT_LVL);
        sp    <= '0;
        pc    <= '0;
        cap_v <= 1'b0;
      end else begin
        cap_v <= is_read(state);
        cap   <= state;
        if (cap_v) begin
          case (cap)
            ST_SP_LO: sp[DATA_W-1:0]        <= rdata;
            ST_SP_HI: sp[2*DATA_W-1:DATA_W] <= rdata;
            ST_PC_LO: pc[DATA_W-1:0]        <= rdata;
            ST_PC_HI: pc[2*DATA_W-1:DATA_W] <= rdata;
            default: ;
          endcase
        end
      end
    end
  end

  AST_BRK_CPU_ONLY: assert property (@(posedge clk) disable iff (rst)
    (brk_req && !hw_req) |=> (cpu_rst && !sfr_rst && !pwr_rst)); // R4
  AST_HW_FULL: assert property (@(posedge clk) disable iff (rst)
    hw_req |=> (cpu_rst && sfr_rst && pwr_rst)); // R5
  AST_RELEASE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst) |-> (state == ST_RUN)); // R11
  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PC_LO) |-> ($past(state) == ST_SP_HI)); // R11
  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr == A_SP || mem_addr == A_SP + 1'b1 || mem_addr == A_PC ||
                mem_addr == A_PC + 1'b1 || mem_addr == A_BRK || mem_addr == A_BRK + 1'b1)); // R8
endmodule

// File: rtl/rst_hub_ctrl.sv
module rst_hub_ctrl
  import rst_hub_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ILVL_W      = 2,
  parameter int PIN_MIN_LOW = 2,
  parameter int BRK_ALT_MAX = 1,
  parameter int SP_VEC      = 0,
  parameter int PC_VEC      = 2,
  parameter int PC_BRK_VEC  = 4
) (
  input  logic                clk,
  input  logic                por_pulse,
  input  logic                ext_rst_n,
  input  logic                osc_stop,
  input  logic                wdt_ovf,
  input  logic                wdt_pend_clr,
  input  logic                brk_req,
  input  logic [ILVL_W-1:0]   brk_ilvl,
  input  logic [SRC_N-1:0]    cause_clr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                cpu_rst,
  output logic                sfr_rst,
  output logic                pwr_rst,
  output logic                mem_re,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] sp_q,
  output logic [2*DATA_W-1:0] pc_q,
  output logic [SRC_N-1:0]    cause_q,
  output logic                wdt_pending
);
  logic pin_req, wdt_fire, hw_req;
  logic [SRC_N-1:0] cause_set;

  rst_pin_filt #(.MIN_LOW(PIN_MIN_LOW)) u_pin (
    .clk(clk), .rst(por_pulse), .pin_n(ext_rst_n), .req(pin_req)
  );

  rst_wdt_arm u_wdt (
    .clk(clk), .rst(por_pulse), .clr_hw(sfr_rst), .ovf(wdt_ovf),
    .sw_clr(wdt_pend_clr), .pend(wdt_pending), .fire(wdt_fire)
  );

  assign hw_req = pin_req || osc_stop || wdt_fire;

  always_comb begin
    cause_set          = '0;
    cause_set[SRC_PIN] = pin_req;
    cause_set[SRC_OSC] = osc_stop;
    cause_set[SRC_WDT] = wdt_fire;
    cause_set[SRC_BRK] = brk_req;
  end

  rst_cause_reg u_cause (
    .clk(clk), .rst(por_pulse), .set(cause_set), .clr(cause_clr), .cause(cause_q)
  );

  rst_vec_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ILVL_W(ILVL_W), .BRK_ALT_MAX(BRK_ALT_MAX),
    .SP_VEC(SP_VEC), .PC_VEC(PC_VEC), .PC_BRK_VEC(PC_BRK_VEC)
  ) u_seq (
    .clk(clk), .rst(por_pulse), .hw_req(hw_req), .brk_req(brk_req),
    .brk_ilvl(brk_ilvl), .rdata(mem_rdata), .cpu_rst(cpu_rst), .sfr_rst(sfr_rst),
    .pwr_rst(pwr_rst), .mem_re(mem_re), .mem_addr(mem_addr), .sp(sp_q), .pc(pc_q)
  );

  AST_NO_DOUBLE_FIRE: assert property (@(posedge clk) disable iff (por_pulse)
    wdt_fire |=> !wdt_pending); // R3
endmodule

// File: tb/rst_hub_ctrl_tb.sv
`timescale 1ns/1ps
module rst_hub_ctrl_tb;
  logic        clk = 1'b0;
  logic        por_pulse = 1'b1, ext_rst_n = 1'b1, osc_stop = 1'b0;
  logic        wdt_ovf = 1'b0, wdt_pend_clr = 1'b0, brk_req = 1'b0;
  logic [1:0]  brk_ilvl = 2'd0;
  logic [4:0]  cause_clr = 5'd0;
  logic [7:0]  mem_rdata = 8'd0;
  logic        cpu_rst, sfr_rst, pwr_rst, mem_re, wdt_pending;
  logic [15:0] mem_addr, sp_q, pc_q;
  logic [4:0]  cause_q;

  int checks = 0, failures = 0;
  bit done = 0;
  int log_a [8];
  int log_n = 0;
  bit saw_rst, saw_sfr, saw_pwr, dropped;
  int ncyc;

  always #2 clk = ~clk;

  rst_hub_ctrl u_dut (
    .clk(clk), .por_pulse(por_pulse), .ext_rst_n(ext_rst_n), .osc_stop(osc_stop),
    .wdt_ovf(wdt_ovf), .wdt_pend_clr(wdt_pend_clr), .brk_req(brk_req),
    .brk_ilvl(brk_ilvl), .cause_clr(cause_clr), .mem_rdata(mem_rdata),
    .cpu_rst(cpu_rst), .sfr_rst(sfr_rst), .pwr_rst(pwr_rst), .mem_re(mem_re),
    .mem_addr(mem_addr), .sp_q(sp_q), .pc_q(pc_q), .cause_q(cause_q),
    .wdt_pending(wdt_pending)
  );

  function automatic logic [7:0] mbyte(input int a);
    return 8'((a * 29 + 7) ^ 8'h5A);
  endfunction
  function automatic logic [15:0] exp_sp();
    return {mbyte(1), mbyte(0)};
  endfunction
  function automatic logic [15:0] exp_pc(input bit alt);
    return alt ? {mbyte(5), mbyte(4)} : {mbyte(3), mbyte(2)};
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= mbyte(int'(mem_addr));
      if (log_n < 8) log_a[log_n] = int'(mem_addr);
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_release();
    saw_rst = 0; saw_sfr = 0; saw_pwr = 0; dropped = 0; ncyc = 1;
    for (int i = 0; i < 60; i++) begin
      saw_rst |= cpu_rst; saw_sfr |= sfr_rst; saw_pwr |= pwr_rst;
      if (saw_rst && !cpu_rst) break;
      tick(); ncyc++;
    end
  endtask

  task automatic clear_cause();
    cause_clr = 5'h1F; tick(); cause_clr = 5'h00; tick();
    chk(cause_q == 5'h00, "R12 clear", cause_q, 5'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(cpu_rst && sfr_rst && pwr_rst, "R5 por resets", {cpu_rst, sfr_rst, pwr_rst}, 3'b111);
    chk(cause_q == 5'b00010, "R13 por cause", cause_q, 5'b00010);
    por_pulse = 1'b0; log_n = 0;
    wait_release();
    chk(sp_q == exp_sp(), "R6 sp after por", sp_q, exp_sp());
    chk(pc_q == exp_pc(0), "R7 pc after por", pc_q, exp_pc(0));
    chk(saw_rst && !cpu_rst, "R1 por fetch done", cpu_rst, 0);

    // R2: a one-cycle pin glitch is filtered
    ext_rst_n = 1'b0; tick(); ext_rst_n = 1'b1;
    saw_rst = 0;
    for (int i = 0; i < 10; i++) begin tick(); saw_rst |= cpu_rst; end
    chk(!saw_rst, "R2 glitch ignored", saw_rst, 0);

    // R3: clearing between overflows prevents reset
    wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
    chk(wdt_pending && !cpu_rst, "R3 first ovf pends", {wdt_pending, cpu_rst}, 2'b10);
    wdt_pend_clr = 1'b1; tick(); wdt_pend_clr = 1'b0;
    chk(!wdt_pending, "R3 sw clear", wdt_pending, 0);
    wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
    saw_rst = 0;
    for (int i = 0; i < 6; i++) begin tick(); saw_rst |= cpu_rst; end
    chk(!saw_rst && wdt_pending, "R3 no reset after clear", {saw_rst, wdt_pending}, 2'b01);
    wdt_pend_clr = 1'b1; tick(); wdt_pend_clr = 1'b0;

    // Sweep: every requester against every interrupt level
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        bit hw, alt;
        logic [4:0] ecause;
        hw  = (s != 3);
        alt = (s == 3) && (l <= 1);
        ecause = (s == 0) ? 5'b00001 : (s == 1) ? 5'b00100 : (s == 2) ? 5'b01000 : 5'b10000;
        clear_cause();
        brk_ilvl = 2'(l);
        if (s == 2) begin
          wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0;
          chk(wdt_pending && !cpu_rst, "R3 pend before second", {wdt_pending, cpu_rst}, 2'b10);
        end
        log_n = 0;
        case (s)
          0: begin ext_rst_n = 1'b0; tick(); tick(); ext_rst_n = 1'b1; end
          1: begin osc_stop = 1'b1; tick(); osc_stop = 1'b0; end
          2: begin wdt_ovf = 1'b1; tick(); wdt_ovf = 1'b0; end
          default: begin brk_req = 1'b1; tick(); brk_req = 1'b0; end
        endcase
        if (s == 3)
          chk(cpu_rst && !sfr_rst && !pwr_rst, "R4 brk first cycle", {cpu_rst, sfr_rst, pwr_rst}, 3'b100);
        if (s == 1)
          chk(cpu_rst && sfr_rst && pwr_rst, "R5 hw next edge", {cpu_rst, sfr_rst, pwr_rst}, 3'b111);
        wait_release();
        chk(saw_rst && !cpu_rst, "R1 source resets", {saw_rst, cpu_rst}, 2'b10);
        chk(saw_sfr == hw && saw_pwr == hw, "R4 R5 scope", {saw_sfr, saw_pwr}, {hw, hw});
        chk(sp_q == exp_sp(), "R6 sp", sp_q, exp_sp());
        chk(pc_q == exp_pc(alt), alt ? "R8 pc alt" : "R7 pc normal", pc_q, exp_pc(alt));
        chk(log_n == 4 && log_a[0] == 0 && log_a[1] == 1 && log_a[2] == (alt ? 4 : 2) &&
            log_a[3] == (alt ? 5 : 3), "R11 read order", log_a[2], alt ? 4 : 2);
        chk(cause_q == ecause, "R12 cause bit", cause_q, ecause);
        if (s == 3) chk(ncyc == 7, "R11 release latency", ncyc, 7);
        if (s == 2) chk(!wdt_pending, "R3 pend cleared by reset", wdt_pending, 0);
      end
    end

    // R9: break and hardware together
    brk_ilvl = 2'd0; brk_req = 1'b1; osc_stop = 1'b1; tick(); brk_req = 1'b0; osc_stop = 1'b0;
    wait_release();
    chk(saw_sfr && saw_pwr && pc_q == exp_pc(0), "R9 hw wins", pc_q, exp_pc(0));

    // R10: request during a fetch
    clear_cause();
    brk_ilvl = 2'd0; brk_req = 1'b1; tick(); brk_req = 1'b0;
    tick(); tick(); tick();
    osc_stop = 1'b1; tick(); osc_stop = 1'b0;
    saw_rst = 0;
    for (int i = 0; i < 60; i++) begin
      if (!cpu_rst) break;
      tick();
    end
    chk(sp_q == exp_sp() && pc_q == exp_pc(0), "R10 refetch normal", pc_q, exp_pc(0));
    chk(cause_q == 5'b10100, "R10 both causes", cause_q, 5'b10100);

    // R12: set wins over clear in the same cycle
    osc_stop = 1'b1; cause_clr = 5'b00100; tick(); osc_stop = 1'b0; cause_clr = 5'b0;
    chk(cause_q[2] == 1'b1, "R12 set beats clear", cause_q, 5'b10100);
    wait_release();

    // R13: power-on drops other causes
    por_pulse = 1'b1; tick(); tick();
    chk(cause_q == 5'b00010, "R13 por clears others", cause_q, 5'b00010);
    por_pulse = 1'b0;
    wait_release();
    chk(pc_q == exp_pc(0) && sp_q == exp_sp(), "R1 por refetch", pc_q, exp_pc(0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule